// File: doc/BRIEF.md
# Converter Serial Master Controller

This block is the digital half of a sampling converter that drives its own serial link. A single-cycle start request begins a conversion. The block then holds `busy` high for a fixed number of system clocks. At the end of that time it takes a result word from a parallel input, which stands in for the analog core. It generates the serial clock, a frame-valid strobe and the serial data line, and the host shifts the word in from those three lines.

The read-mode input is sampled when a start is accepted and selects one of two schedules. In the after mode, the new result is sent once its conversion ends, and `busy` stays high until the last bit has gone out. In the during mode, the result held from the previous conversion is sent while the new conversion runs, and `busy` falls as soon as the conversion time is over. The serial clock and the frame strobe each have their own polarity-invert input. When the clock-source select is high, the block still converts but drives no serial frames.

Top module: `adc_serial_master`

## Requirements
- R1: While `ext_clk_sel` is 1 when a start is accepted, no frame is sent: `sclk`, `sync` and `sdata` stay at their idle levels, and `busy` is high for exactly CONV_CYCLES clocks in either read mode.
- R2: During a frame, one serial clock period lasts SCLK_DIV system clocks: the first half at the idle level, the second half at the active level. `sdata` changes only while `sclk` is at its idle level, so the host samples on the idle-to-active transition.
- R3: A frame carries RES_BITS data bits, most significant bit first, and `sync` is at its active level for exactly RES_BITS*SCLK_DIV clocks.
- R4: With `sclk_invert`=0 the serial clock idles low; with 1 it idles high. With `sync_invert`=0 `sync` is active high; with 1 it is active low. The data bits are the same under every polarity.
- R5: With `read_during`=0 the frame carries the word present on `core_result` at the end of that start's conversion.
- R6: With `read_during`=1 the frame begins the clock after the start is accepted and carries the result of the previous conversion.
- R7: With `read_during`=0, `busy` is high for CONV_CYCLES + RES_BITS*SCLK_DIV clocks.
- R8: With `read_during`=1, `busy` is high for CONV_CYCLES clocks, even while the frame continues afterwards.
- R9: After reset, `busy` is 0 and the held previous result is zero, so the first frame sent with `read_during`=1 is all zeros.
- R10: A `conv_start` pulse while `busy` is high or a frame is in progress is ignored: `busy` does not rise again and the frame in progress is not disturbed.
- R11: Outside a frame, `sclk` rests at its idle level, `sync` is inactive, and `sdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | Start-of-conversion request, sampled on each clock |
| read_during | input | 1 | 0: send the new result after conversion; 1: send the previous result during conversion |
| sclk_invert | input | 1 | Inverts the serial clock |
| sync_invert | input | 1 | Inverts the frame strobe |
| ext_clk_sel | input | 1 | 1 selects an external clock, which is not implemented; no frames are sent |
| core_result | input | RES_BITS | Result word from the conversion core |
| busy | output | 1 | Conversion (and, in the after mode, transfer) in progress |
| sclk | output | 1 | Generated serial clock |
| sync | output | 1 | Frame-valid strobe |
| sdata | output | 1 | Serial data, most significant bit first |

## Verification
The assertions assume that `sclk_invert`, `sync_invert` and `ext_clk_sel` change only while no frame is in progress. The edge-placement and idle-level properties therefore compare `sclk` and `sync` against fixed polarity settings. The bench changes these inputs only between scenarios, after the monitor window has shown the link idle with `busy` low. It also holds `core_result` steady for the whole conversion, so the word taken at the end of the conversion is known.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
   typedef enum logic {
      RD_AFTER  = 1'b0,
      RD_DURING = 1'b1
   } read_mode_e;

   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
   parameter int CONV_CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic converting,
   output logic done
);
   localparam int CW = adc_ser_pkg::cnt_width(CONV_CYCLES);
   localparam logic [CW-1:0] LOAD = CW'(CONV_CYCLES - 1);

   logic [CW-1:0] remain;

   assign done = converting && (remain == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         converting <= 1'b0;
         remain     <= '0;
      end else if (start) begin
         converting <= 1'b1;
         remain     <= LOAD;
      end else if (done) begin
         converting <= 1'b0;
      end else if (converting) begin
         remain <= remain - 1'b1;
      end
   end
endmodule

// File: rtl/adc_bit_clock.sv
module adc_bit_clock #(
   parameter int SCLK_DIV = 4,
   parameter int RES_BITS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active,
   output logic sclk_raw,
   output logic shift,
   output logic frame_end
);
   localparam int PW   = adc_ser_pkg::cnt_width(SCLK_DIV - 1);
   localparam int BW   = adc_ser_pkg::cnt_width(RES_BITS - 1);
   localparam int HALF = SCLK_DIV / 2;
   localparam logic [PW-1:0] PH_LAST  = PW'(SCLK_DIV - 1);
   localparam logic [BW-1:0] BIT_LAST = BW'(RES_BITS - 1);

   logic [PW-1:0] phase;
   logic [BW-1:0] bitn;
   logic          bit_end;

   assign bit_end   = active && (phase == PH_LAST);
   assign shift     = bit_end && (bitn != BIT_LAST);
   assign frame_end = bit_end && (bitn == BIT_LAST);

   generate
      if (SCLK_DIV == 2) begin : g_div2
         assign sclk_raw = active && phase[0];
      end else begin : g_divn
         assign sclk_raw = active && (phase >= PW'(HALF));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         phase  <= '0;
         bitn   <= '0;
      end else if (start) begin
         active <= 1'b1;
         phase  <= '0;
         bitn   <= '0;
      end else if (active) begin
         if (bit_end) begin
            phase <= '0;
            if (frame_end) active <= 1'b0;
            else           bitn   <= bitn + 1'b1;
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end
endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out #(
   parameter int RES_BITS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [RES_BITS-1:0] load_val,
   input  logic                shift,
   output logic                msb
);
   logic [RES_BITS-1:0] sreg;

   assign msb = sreg[RES_BITS-1];

   always_ff @(posedge clk) begin
      if (!rst_n)     sreg <= '0;
      else if (load)  sreg <= load_val;
      else if (shift) sreg <= {sreg[RES_BITS-2:0], 1'b0};
   end
endmodule

// File: rtl/adc_serial_master.sv
module adc_serial_master #(
   parameter int RES_BITS    = 16,
   parameter int SCLK_DIV    = 4,
   parameter int CONV_CYCLES = 40
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                conv_start,
   input  logic                read_during,
   input  logic                sclk_invert,
   input  logic                sync_invert,
   input  logic                ext_clk_sel,
   input  logic [RES_BITS-1:0] core_result,
   output logic                busy,
   output logic                sclk,
   output logic                sync,
   output logic                sdata
);
   import adc_ser_pkg::*;

   generate
      if (RES_BITS < 2) begin : g_bad_bits
         $error("RES_BITS must be at least 2");
      end
      if (SCLK_DIV < 2 || (SCLK_DIV % 2) != 0) begin : g_bad_div
         $error("SCLK_DIV must be even and at least 2");
      end
      if (CONV_CYCLES < 1) begin : g_bad_conv
         $error("CONV_CYCLES must be at least 1");
      end
   endgenerate

   read_mode_e          mode_q;
   logic                ext_q;
   logic [RES_BITS-1:0] held;
   logic                accept;
   logic                converting;
   logic                conv_done;
   logic                xfer_active;
   logic                sclk_raw;
   logic                shift;
   logic                frame_end;
   logic                frame_start;
   logic                msb;
   logic [RES_BITS-1:0] load_val;

   assign accept = conv_start && !busy && !xfer_active;

   assign frame_start = accept ? (read_during && !ext_clk_sel)
                               : (conv_done && (mode_q == RD_AFTER) && !ext_q);
   assign load_val    = accept ? held : core_result;

   adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .converting (converting),
      .done       (conv_done)
   );

   adc_bit_clock #(.SCLK_DIV(SCLK_DIV), .RES_BITS(RES_BITS)) u_bitclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (frame_start),
      .active    (xfer_active),
      .sclk_raw  (sclk_raw),
      .shift     (shift),
      .frame_end (frame_end)
   );

   adc_shift_out #(.RES_BITS(RES_BITS)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (frame_start),
      .load_val (load_val),
      .shift    (shift),
      .msb      (msb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         mode_q <= RD_AFTER;
         ext_q  <= 1'b0;
         held   <= '0;
      end else begin
         if (accept) begin
            busy   <= 1'b1;
            mode_q <= read_mode_e'(read_during);
            ext_q  <= ext_clk_sel;
         end else if (conv_done && (mode_q == RD_DURING || ext_q)) begin
            busy <= 1'b0;
         end else if (frame_end && mode_q == RD_AFTER && busy) begin
            busy <= 1'b0;
         end
         if (conv_done) held <= core_result;
      end
   end

   assign sclk  = sclk_raw ^ sclk_invert;
   assign sync  = xfer_active ^ sync_invert;
   assign sdata = xfer_active & msb;

   logic unused_conv;
   assign unused_conv = converting;
endmodule

// File: rtl/adc_serial_master_checker.sv
module adc_serial_master_checker #(
   parameter int RES_BITS    = 16,
   parameter int SCLK_DIV    = 4,
   parameter int CONV_CYCLES = 40
) (
   input logic clk,
   input logic rst_n,
   input logic conv_start,
   input logic sclk_invert,
   input logic sync_invert,
   input logic ext_clk_sel,
   input logic busy,
   input logic sclk,
   input logic sync,
   input logic sdata
);
   localparam int FRAME = RES_BITS * SCLK_DIV;
   localparam int FW    = $clog2(FRAME + 2);

   logic          sync_on;
   logic [FW-1:0] run_len;

   assign sync_on = (sync != sync_invert);

   always_ff @(posedge clk) begin
      if (!rst_n)                       run_len <= '0;
      else if (!sync_on)                run_len <= '0;
      else if (run_len != FW'(FRAME+1)) run_len <= run_len + 1'b1;
   end

   assert_busy_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(conv_start));

   assert_idle_levels_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_on |-> (sdata == 1'b0 && sclk == sclk_invert));

   assert_data_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(sclk_invert) && !$stable(sdata)) |-> (sclk == sclk_invert));

   assert_frame_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= FW'(FRAME));

   assert_ext_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_clk_sel && $past(ext_clk_sel) && $past(sync == sync_invert) && $stable(sync_invert))
         |-> (sync == sync_invert));
endmodule

bind adc_serial_master adc_serial_master_checker #(
   .RES_BITS(RES_BITS), .SCLK_DIV(SCLK_DIV), .CONV_CYCLES(CONV_CYCLES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .conv_start  (conv_start),
   .sclk_invert (sclk_invert),
   .sync_invert (sync_invert),
   .ext_clk_sel (ext_clk_sel),
   .busy        (busy),
   .sclk        (sclk),
   .sync        (sync),
   .sdata       (sdata)
);

// File: tb/adc_serial_master_test.sv
module adc_serial_master_test;
   localparam int RB    = 16;
   localparam int DIV   = 4;
   localparam int CONV  = 40;
   localparam int FRAME = RB * DIV;
   localparam int WIN   = 200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          conv_start = 1'b0;
   logic          read_during = 1'b0;
   logic          sclk_invert = 1'b0;
   logic          sync_invert = 1'b0;
   logic          ext_clk_sel = 1'b0;
   logic [RB-1:0] core_result = '0;
   logic          busy, sclk, sync, sdata;

   int tests = 0;
   int fails = 0;

   int            n_busy, n_rises, n_sync, n_bits, gap, idle_bad, sync_first;
   logic [RB-1:0] got;

   always #2.5 clk = ~clk;

   adc_serial_master #(.RES_BITS(RB), .SCLK_DIV(DIV), .CONV_CYCLES(CONV)) uut (
      .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .read_during(read_during),
      .sclk_invert(sclk_invert), .sync_invert(sync_invert), .ext_clk_sel(ext_clk_sel),
      .core_result(core_result), .busy(busy), .sclk(sclk), .sync(sync), .sdata(sdata)
   );

   task automatic check(input string req, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   // start pulse then watch WIN cycles; optional second pulse at cycle extra_at
   task automatic run_conv(input int extra_at);
      int prev_act, prev_busy, first_edge;
      @(negedge clk);
      conv_start = 1'b1;
      @(negedge clk);
      conv_start = 1'b0;
      n_busy = 0; n_rises = 0; n_sync = 0; n_bits = 0; gap = 0; idle_bad = 0;
      sync_first = -1; got = '0; prev_act = 0; prev_busy = 0; first_edge = -1;
      for (int c = 0; c < WIN; c++) begin
         int act;
         if (c == extra_at) conv_start = 1'b1;
         else               conv_start = 1'b0;
         act = (sclk != sclk_invert);
         if (busy) n_busy++;
         if (busy && !prev_busy) n_rises++;
         if (sync != sync_invert) begin
            n_sync++;
            if (sync_first < 0) sync_first = c;
            if (act && !prev_act) begin
               if (n_bits < RB) got[RB-1-n_bits] = sdata;
               n_bits++;
               if (first_edge < 0) first_edge = c;
               else if (gap == 0)  gap = c - first_edge;
            end
         end else if (act || sdata) begin
            idle_bad++;
         end
         prev_act = act;
         prev_busy = busy;
         @(negedge clk);
      end
      conv_start = 1'b0;
   endtask

   task automatic t_reset();
      check("R9 busy after reset", busy, 0);
      check("R11 sclk idle after reset", sclk, 0);
      check("R11 sync idle after reset", sync, 0);
      check("R11 sdata idle after reset", sdata, 0);
   endtask

   task automatic t_during_first();
      read_during = 1'b1; core_result = 16'h1234;
      run_conv(-1);
      check("R9 first during-frame is zero", got, 0);
      check("R8 busy width during mode", n_busy, CONV);
      check("R6 frame starts right after start", sync_first, 0);
      check("R3 bit count", n_bits, RB);
   endtask

   task automatic t_during_prev();
      read_during = 1'b1; core_result = 16'hBEEF;
      run_conv(-1);
      check("R6 previous result sent", got, 16'h1234);
      check("R3 sync width", n_sync, FRAME);
   endtask

   task automatic t_after();
      read_during = 1'b0; core_result = 16'hA5C3;
      run_conv(-1);
      check("R5 new result sent", got, 16'hA5C3);
      check("R7 busy width after mode", n_busy, CONV + FRAME);
      check("R5 frame starts after conversion", sync_first, CONV);
      check("R2 serial clock period", gap, DIV);
      check("R11 idle outside frame", idle_bad, 0);
   endtask

   task automatic t_inverted();
      sclk_invert = 1'b1; sync_invert = 1'b1;
      @(negedge clk);
      check("R4 sclk idles high", sclk, 1);
      check("R4 sync inactive high", sync, 1);
      read_during = 1'b0; core_result = 16'h8001;
      run_conv(-1);
      check("R4 data under inversion", got, 16'h8001);
      check("R4 sync width under inversion", n_sync, FRAME);
      check("R11 idle under inversion", idle_bad, 0);
      sclk_invert = 1'b0; sync_invert = 1'b0;
   endtask

   task automatic t_ignore();
      read_during = 1'b0; core_result = 16'h0F0F;
      run_conv(20);
      check("R10 no restart in conversion", n_rises, 1);
      check("R10 busy width kept", n_busy, CONV + FRAME);
      check("R10 data kept", got, 16'h0F0F);
      read_during = 1'b1; core_result = 16'h7777;
      run_conv(50);
      check("R10 no restart during frame", n_rises, 1);
      check("R10 during frame data kept", got, 16'h0F0F);
      check("R10 busy width during mode", n_busy, CONV);
   endtask

   task automatic t_external();
      ext_clk_sel = 1'b1;
      read_during = 1'b0; core_result = 16'h4321;
      run_conv(-1);
      check("R1 no sync with ext select", n_sync, 0);
      check("R1 busy width ext after-mode", n_busy, CONV);
      check("R1 outputs idle", idle_bad, 0);
      read_during = 1'b1;
      run_conv(-1);
      check("R1 no sync ext during-mode", n_sync, 0);
      check("R1 busy width ext during-mode", n_busy, CONV);
      ext_clk_sel = 1'b0;
      read_during = 1'b1; core_result = 16'h0000;
      run_conv(-1);
      check("R1 conversion still captured", got, 16'h4321);
   endtask

   initial begin
      #(5.0 * 200000);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_during_first();
      t_during_prev();
      t_after();
      t_inverted();
      t_ignore();
      t_external();
      finish_run();
   end
endmodule